// File: doc/BRIEF.md
# PCI Configuration Port Decoder

This block gives software access to PCI configuration space through two 32-bit I/O ports on an 8-bit I/O bus. The address port holds a selector (bus, device, function), a dword register index and an enable bit. The data port carries write data and returns lookup results. Both ports are accessed one byte lane at a time. Lane n of each port sits at the port base plus n and carries bits 8n+7:8n.

Writing the top lane of the address port completes the address and starts a read lookup into a configuration-space back end. Writing the top lane of the data port sends the assembled dword as a write to the latched address. The back end answers in the request cycle. It reports whether the device is present, whether the offset lies inside the device's space, and the addressed dword. The result is kept in a response word and a status word, which are read back through the data port and the address port.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset, every lane of the response word and of the status word reads 0.
- R2: A write to address-port lane n (0xCF8+n) changes only bits 8n+7:8n of the latched address. The other lanes keep their values.
- R3: Writing address-port lane 3 (0xCF8+3) raises `be_req` with `be_we`=0 for exactly the next cycle. In that cycle `be_sel` is address bits 23:8 and `be_off` is address bits 7:2, so address bits 1:0 have no effect.
- R4: Address bit 31 appears on `be_enable` during a request. Its value does not gate the lookup or change the result.
- R5: A lookup of a present device with an in-range offset sets the response to `be_rdata` and the status to 0x80000000.
- R6: A lookup of a present device with an out-of-range offset sets the response to 0 and the status to 0x80000000.
- R7: A lookup with no device present sets the response to 0xFFFFFFFF and the status to 0.
- R8: Reading 0xCFC+n returns response bits 8n+7:8n. Reading 0xCF8+n returns status bits 8n+7:8n. Any other I/O address reads 0.
- R9: Writing data-port lane 3 (0xCFC+3) raises `be_req` with `be_we`=1 for the next cycle. `be_wdata` carries the four data lanes, lane n in bits 8n+7:8n. The response and status words are left unchanged.
- R10: `be_commit` is asserted only during a write request to a present device. A write to an absent device is dropped.
- R11: A read issued in the request cycle of a lookup returns the previous response. The new value appears from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O byte address |
| io_wr | input | 1 | I/O write strobe, one cycle per byte |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 8 | I/O read byte, combinational on `io_addr` |
| be_req | output | 1 | Back-end request pulse |
| be_we | output | 1 | Request is a write |
| be_sel | output | 16 | Device selector: bus, device, function |
| be_off | output | 6 | Dword register index |
| be_enable | output | 1 | Enable bit from the address |
| be_wdata | output | 32 | Write dword |
| be_present | input | 1 | Selected device exists |
| be_inrange | input | 1 | Offset lies inside the device's space |
| be_rdata | input | 32 | Addressed dword |
| be_commit | output | 1 | Back end may apply the write |

## Verification
A host read of a result lane can land in the same cycle that a lookup captures its response. The bench provokes this by placing the data-port address on the bus in the request cycle, right after the address write. It expects the byte from the previous lookup and the new byte one cycle later. The second overlap is a write request and the capture logic sharing that cycle. There the bench requires the response lanes to read unchanged after a data write to a present device and to an absent one. It also counts any commit to an absent device seen at `be_commit`.

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder #(
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        be_req,
  output logic        be_we,
  output logic [15:0] be_sel,
  output logic [5:0]  be_off,
  output logic        be_enable,
  output logic [31:0] be_wdata,
  input  logic        be_present,
  input  logic        be_inrange,
  input  logic [31:0] be_rdata,
  output logic        be_commit
);

  logic [31:0] addr_q, data_q, resp_q, stat_q;
  logic        req_q, we_q;
  logic        hit_a, hit_d;
  logic [1:0]  lane;
  logic [31:0] rd_word;

  assign hit_a = io_addr[15:2] == ADDR_PORT[15:2];
  assign hit_d = io_addr[15:2] == DATA_PORT[15:2];
  assign lane  = io_addr[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      resp_q <= '0;
      stat_q <= '0;
      req_q  <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      req_q <= io_wr && (hit_a || hit_d) && (lane == 2'd3);
      we_q  <= hit_d;
      if (io_wr && hit_a) addr_q[{lane, 3'b000} +: 8] <= io_wdata;
      if (io_wr && hit_d) data_q[{lane, 3'b000} +: 8] <= io_wdata;
      if (req_q && !we_q) begin
        if (be_present) begin
          stat_q <= 32'h8000_0000;
          resp_q <= be_inrange ? be_rdata : 32'h0;
        end else begin
          stat_q <= 32'h0;
          resp_q <= 32'hFFFF_FFFF;
        end
      end
    end
  end

  assign be_req    = req_q;
  assign be_we     = we_q;
  assign be_sel    = addr_q[23:8];
  assign be_off    = addr_q[7:2];
  assign be_enable = addr_q[31];
  assign be_wdata  = data_q;
  assign be_commit = req_q && we_q && be_present;

  assign rd_word  = hit_d ? resp_q : (hit_a ? stat_q : 32'h0);
  assign io_rdata = rd_word[{lane, 3'b000} +: 8];

endmodule

module cfg_port_decoder_chk #(
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic        io_wr,
  input logic        be_req,
  input logic        be_we,
  input logic        be_present,
  input logic        be_inrange,
  input logic [31:0] be_rdata,
  input logic        be_commit,
  input logic [31:0] resp_q,
  input logic [31:0] stat_q
);

  assert_addr_lookup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && io_addr == ADDR_PORT + 16'd3 |=> be_req && !be_we);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && !io_wr |=> !be_req);

  assert_present_R5: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && !be_we && be_present && be_inrange |=>
      resp_q == $past(be_rdata) && stat_q == 32'h8000_0000);

  assert_absent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && !be_we && !be_present |=> resp_q == 32'hFFFF_FFFF && stat_q == 32'h0);

  assert_data_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && io_addr == DATA_PORT + 16'd3 |=> be_req && be_we);

  assert_keep_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && be_we |=> $stable(resp_q) && $stable(stat_q));

  assert_drop_absent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    be_commit |-> be_req && be_we && be_present);

endmodule

bind cfg_port_decoder cfg_port_decoder_chk #(.ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
  .be_req(be_req), .be_we(be_we), .be_present(be_present), .be_inrange(be_inrange),
  .be_rdata(be_rdata), .be_commit(be_commit), .resp_q(resp_q), .stat_q(stat_q)
);

// File: tb/tb_cfg_port_decoder.sv
`timescale 1ns/1ps
module tb_cfg_port_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata;
  logic        be_req, be_we, be_enable, be_commit;
  logic [15:0] be_sel;
  logic [5:0]  be_off;
  logic [31:0] be_wdata, be_rdata;
  logic        be_present, be_inrange;

  int total = 0, bad = 0, absent_commits = 0;
  logic [31:0] exp_resp = 32'h0;
  logic [31:0] mem [0:2][0:15];

  always #4 clk = ~clk;

  cfg_port_decoder dut (.*);

  function automatic int dev_idx(input logic [15:0] s);
    if (s == 16'h0000) return 0;
    if (s == 16'h0008) return 1;
    if (s == 16'h0123) return 2;
    return -1;
  endfunction

  function automatic logic [31:0] init_word(input int d, input int o);
    return {8'(d * 16 + 3), 8'(o), 8'hC3, 8'(o * 7 + d)};
  endfunction

  assign be_present = dev_idx(be_sel) >= 0;
  assign be_inrange = be_off < 6'd16;
  assign be_rdata   = be_present ? mem[dev_idx(be_sel) < 0 ? 0 : dev_idx(be_sel)][be_off[3:0]] : 32'hDEAD_BEEF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < 3; d++)
        for (int o = 0; o < 16; o++) mem[d][o] <= init_word(d, o);
    end else if (be_commit) begin
      if (!be_present) absent_commits <= absent_commits + 1;
      else if (be_inrange) mem[dev_idx(be_sel)][be_off[3:0]] <= be_wdata;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic read_word(input logic [15:0] base, output logic [31:0] w);
    for (int n = 0; n < 4; n++) begin
      io_addr = base + 16'(n);
      #1 w[n*8 +: 8] = io_rdata;
    end
  endtask

  task automatic lookup(input logic [15:0] s, input logic [5:0] o, input logic [1:0] lo, input logic en);
    logic [31:0] a, w, st, e;
    int d;
    a = {en, 7'h0, s, o, lo};
    io_write(16'h0CF8, a[7:0]);
    io_write(16'h0CF9, a[15:8]);
    io_write(16'h0CFA, a[23:16]);
    io_write(16'h0CFB, a[31:24]);
    // request cycle
    io_addr = 16'h0CFC;
    #1;
    check("R3 req", {be_req, be_we}, 2'b10);
    check("R3 sel/off", {be_sel, 10'(be_off)}, {s, 4'h0, o});
    check("R4 enable", be_enable, en);
    check("R11 old resp in request cycle", io_rdata, exp_resp[7:0]);
    @(negedge clk);
    d = dev_idx(s);
    e = (d < 0) ? 32'hFFFF_FFFF : (o < 16 ? mem[d][o[3:0]] : 32'h0);
    read_word(16'h0CFC, w);
    read_word(16'h0CF8, st);
    if (d < 0) check("R7 resp", w, e);
    else if (o < 16) check("R5 resp", w, e);
    else check("R6 resp", w, e);
    check(d < 0 ? "R7 status" : "R5 status", st, d < 0 ? 32'h0 : 32'h8000_0000);
    exp_resp = e;
  endtask

  task automatic data_write(input logic [31:0] v);
    logic [31:0] w;
    for (int n = 0; n < 4; n++) io_write(16'h0CFC + 16'(n), v[n*8 +: 8]);
    #1;
    check("R9 req", {be_req, be_we}, 2'b11);
    check("R9 wdata", be_wdata, v);
    @(negedge clk);
    read_word(16'h0CFC, w);
    check("R9 resp unchanged", w, exp_resp);
  endtask

  logic [15:0] sels [0:5] = '{16'h0000, 16'h0008, 16'h0123, 16'h0010, 16'h0124, 16'hFFFF};

  initial begin
    fork
      begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_word(16'h0CFC, w); check("R1 resp reset", w, 32'h0);
        read_word(16'h0CF8, w); check("R1 status reset", w, 32'h0);
        for (int i = 0; i < 6; i++)
          for (int o = 0; o < 64; o++)
            lookup(sels[i], 6'(o), 2'(o * 3), o[0]);
        // R2: only lane 1 changes; selector 0x0000 -> 0x0008
        lookup(16'h0000, 6'd5, 2'b00, 1'b0);
        io_write(16'h0CF9, 8'h08);
        io_write(16'h0CFB, 8'h00);
        #1 check("R2 lane-only update", {be_sel, 10'(be_off)}, {16'h0008, 10'd5});
        @(negedge clk);
        read_word(16'h0CFC, w);
        check("R2 lookup after partial", w, mem[1][5]);
        exp_resp = w;
        // R9/R10: write to present device then read back
        lookup(16'h0123, 6'd3, 2'b00, 1'b1);
        data_write(32'h4433_2211);
        lookup(16'h0123, 6'd3, 2'b00, 1'b1);
        check("R9 write landed", exp_resp, 32'h4433_2211);
        // write to absent device is dropped
        lookup(16'h0010, 6'd3, 2'b00, 1'b1);
        data_write(32'hCAFE_F00D);
        check("R10 absent commits", absent_commits, 0);
        read_word(16'h0CF8, w);
        check("R10 status unchanged", w, 32'h0);
        // R8: unrelated addresses
        io_addr = 16'h0CF7; #1 check("R8 below", io_rdata, 8'h00);
        io_addr = 16'h0D00; #1 check("R8 above", io_rdata, 8'h00);
      end
      begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule